// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits between an asynchronous 8-bit microprocessor bus and four identical register-file channels inside a multi-channel serial controller. The bus style is chosen by one mode pin. With the mode pin high, the host uses separate active-low read and write strobes, and each channel has its own active-low select. With the mode pin low, the host uses one active-low device select. The write-strobe pin becomes a direction line (1 = read, 0 = write), and two further select pins become channel address bits.

Every bus pin, including the register address and the data byte, passes through a two-flop synchronizer, so all of them move together into the internal clock domain. A small controller finds the start and end of each access. It issues exactly one clock-wide read or write request to the register files, and that request carries a channel index, a 3-bit register offset and, for writes, a data byte. The byte returned for a read is captured once and presented on the data output for as long as the read lasts. The output enable drives the pad tri-state control, so the bus is released at all other times. The pad buffer itself lies outside the block.

Top module: `hostBusPort`

## Requirements
- R1: `modeSep` = 1 selects separate-strobe operation, and `modeSep` = 0 selects combined-strobe operation. Strobes of the style that is not selected cause no request.
- R2: After reset, `reqRead`, `reqWrite` and `dataOe` are 0.
- R3: In separate mode, a falling edge on `rdN` while exactly one bit of `csN` is low produces one `reqRead`. The request carries `reqChan` equal to the index of that low bit and `reqReg` equal to `addrIn`. The byte on `regRdData` during that pulse then appears on `dataOut` with `dataOe` = 1 until `rdN` rises.
- R4: In separate mode, a fall of `wrN` while exactly one `csN` bit is low opens a write. The rise of `wrN` then produces one `reqWrite`. The request carries the channel and register taken at the fall, and the `dataIn` value present when the rise is sampled, not the value present at the fall.
- R5: In separate mode, a strobe edge while zero or more than one `csN` bit is low produces no request and leaves `dataOe` at 0.
- R6: In combined mode, the access direction is read from `wrN` at the fall of `csN[0]` (1 = read, 0 = write), and `rdN` has no effect.
- R7: In combined mode, `csN[0]` is the active-low device select, `reqChan` = {`csN[2]`,`csN[1]`}, and `csN[3]` has no effect.
- R8: In combined mode, a write commits with one `reqWrite` when `csN[0]` rises, carrying the `dataIn` value present when that rise is sampled. A read holds `dataOe` = 1 with the captured byte until `csN[0]` rises.
- R9: `reqRead` and `reqWrite` are each exactly one clock cycle wide per access, and they are never high in the same cycle.
- R10: `dataOe` is 1 only during a read, and `dataOut` stays constant while `dataOe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSep | input | 1 | 1 = separate strobes, 0 = combined strobe with direction line |
| rdN | input | 1 | Read strobe, active low (ignored in combined mode) |
| wrN | input | 1 | Write strobe (separate) or direction, 1 = read (combined) |
| csN | input | 4 | Per-channel selects (separate); [0] device select, [2:1] channel bits (combined) |
| addrIn | input | 3 | Register offset within the channel |
| dataIn | input | 8 | Data bus as seen from the pad |
| dataOut | output | 8 | Read byte to the pad |
| dataOe | output | 1 | Pad output enable, 1 drives the bus |
| reqRead | output | 1 | One-cycle read request to the register files |
| reqWrite | output | 1 | One-cycle write request to the register files |
| reqChan | output | 2 | Channel index of the request |
| reqReg | output | 3 | Register offset of the request |
| reqWData | output | 8 | Write byte of the request |
| regRdData | input | 8 | Byte returned by the addressed register during `reqRead` |

## Verification
On every cycle, the embedded properties check that each request lasts one cycle and that read and write never overlap. They also check that a write only ever comes out of an open write, that a multi-select read edge issues nothing, that the output enable only rises right after a read request, and that the driven byte never moves while it is enabled. Only the bench's scenarios can show the functional mapping. That covers which channel and register a given pin pattern reaches under each mode, that the write byte is the one present at the closing edge, that the read byte matches the addressed register, and that the pins the active mode ignores really are ignored. The bench sweeps every channel and register in both modes, both directions, and the illegal select patterns.

// File: rtl/hostBusPkg.sv
package hostBusPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchCtx;     // capture channel and register of a starting access
    logic latchRdData;  // capture register byte returned for a read
    logic latchWrData;  // capture bus byte at the closing edge of a write
  } ctrlStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD_CAP   = 2'd1,
    ST_RD_DRIVE = 2'd2,
    ST_WR_PEND  = 2'd3
  } busState_t;

endpackage

// File: rtl/hostBusSync.sv
module hostBusSync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= IDLE_VAL;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= IDLE_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/hostBusCtrl.sv
module hostBusCtrl
  import hostBusPkg::*;
#(
  parameter int NUM_CHAN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSep,
  input  logic                rdS,
  input  logic                wrS,
  input  logic [NUM_CHAN-1:0] csS,
  output ctrlStrb_t           strb,
  output logic                reqRead,
  output logic                reqWrite,
  output logic                dataOe
);

  localparam int CNT_W = $clog2(NUM_CHAN + 1);

  busState_t state, stateNext;
  logic rdPrev, wrPrev, selPrev;
  logic rdFall, rdRise, wrFall, wrRise, selFall, selRise;
  logic [CNT_W-1:0] selCnt;
  logic oneSel;
  logic startRd, startWr, endRd, endWr;

  // Edge history of synchronized strobes (idle level is high)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev  <= 1'b1;
      wrPrev  <= 1'b1;
      selPrev <= 1'b1;
    end else begin
      rdPrev  <= rdS;
      wrPrev  <= wrS;
      selPrev <= csS[0];
    end
  end

  assign rdFall  = rdPrev & ~rdS;
  assign rdRise  = ~rdPrev & rdS;
  assign wrFall  = wrPrev & ~wrS;
  assign wrRise  = ~wrPrev & wrS;
  assign selFall = selPrev & ~csS[0];
  assign selRise = ~selPrev & csS[0];

  // Count asserted per-channel selects
  always_comb begin
    selCnt = '0;
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (!csS[i]) selCnt = selCnt + 1'b1;
    end
  end
  assign oneSel = (selCnt == CNT_W'(1));

  // Access boundaries for the two bus styles
  always_comb begin
    if (modeSep) begin
      startRd = rdFall & oneSel;
      startWr = wrFall & oneSel & ~rdFall;
      endRd   = rdRise;
      endWr   = wrRise;
    end else begin
      startRd = selFall & wrS;
      startWr = selFall & ~wrS;
      endRd   = selRise;
      endWr   = selRise;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startRd)      stateNext = ST_RD_CAP;
        else if (startWr) stateNext = ST_WR_PEND;
      end
      ST_RD_CAP:   stateNext = endRd ? ST_IDLE : ST_RD_DRIVE;
      ST_RD_DRIVE: if (endRd) stateNext = ST_IDLE;
      ST_WR_PEND:  if (endWr) stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      reqRead  <= 1'b0;
      reqWrite <= 1'b0;
    end else begin
      state    <= stateNext;
      reqRead  <= (state == ST_IDLE) & startRd;
      reqWrite <= (state == ST_WR_PEND) & endWr;
    end
  end

  assign strb.latchCtx    = (state == ST_IDLE) & (startRd | startWr);
  assign strb.latchRdData = (state == ST_RD_CAP);
  assign strb.latchWrData = (state == ST_WR_PEND) & endWr;
  assign dataOe           = (state == ST_RD_DRIVE);

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) reqRead |=> !reqRead); // R9
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) reqWrite |=> !reqWrite); // R9
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rstN) !(reqRead && reqWrite)); // R9
  AST_WRITE_FROM_PEND: assert property (@(posedge clk) disable iff (!rstN) $rose(reqWrite) |-> $past(state) == ST_WR_PEND); // R4
  AST_MULTI_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rstN) (modeSep && rdFall && !oneSel && state == ST_IDLE) |=> !reqRead); // R5

endmodule

// File: rtl/hostBusDatapath.sv
module hostBusDatapath
  import hostBusPkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int CHAN_W = $clog2(NUM_CHAN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSep,
  input  logic [NUM_CHAN-1:0] csS,
  input  logic [ADDR_W-1:0]   addrS,
  input  logic [DATA_W-1:0]   dataS,
  input  ctrlStrb_t           strb,
  input  logic [DATA_W-1:0]   regRdData,
  output logic [CHAN_W-1:0]   reqChan,
  output logic [ADDR_W-1:0]   reqReg,
  output logic [DATA_W-1:0]   reqWData,
  output logic [DATA_W-1:0]   dataOut
);

  logic [CHAN_W-1:0] sepIdx, chanDec;
  logic [DATA_W-1:0] rdHold;

  // Separate mode: index of the low select line
  always_comb begin
    sepIdx = '0;
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (!csS[i]) sepIdx = CHAN_W'(i);
    end
  end

  // Combined mode: select lines above the device select carry the channel
  assign chanDec = modeSep ? sepIdx : csS[CHAN_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqChan  <= '0;
      reqReg   <= '0;
      reqWData <= '0;
      rdHold   <= '0;
    end else begin
      if (strb.latchCtx) begin
        reqChan <= chanDec;
        reqReg  <= addrS;
      end
      if (strb.latchRdData) rdHold   <= regRdData;
      if (strb.latchWrData) reqWData <= dataS;
    end
  end

  assign dataOut = rdHold;

  AST_CTX_STABLE_UNLESS_START: assert property (@(posedge clk) disable iff (!rstN) !strb.latchCtx |=> $stable(reqChan) && $stable(reqReg)); // R4

endmodule

// File: rtl/hostBusPort.sv
module hostBusPort
  import hostBusPkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CHAN_W = $clog2(NUM_CHAN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSep,
  input  logic                rdN,
  input  logic                wrN,
  input  logic [NUM_CHAN-1:0] csN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  output logic                reqRead,
  output logic                reqWrite,
  output logic [CHAN_W-1:0]   reqChan,
  output logic [ADDR_W-1:0]   reqReg,
  output logic [DATA_W-1:0]   reqWData,
  input  logic [DATA_W-1:0]   regRdData
);

  localparam int SYNC_W = 2 + NUM_CHAN + ADDR_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_IDLE = {2'b11, {NUM_CHAN{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

  logic [SYNC_W-1:0] syncBus;
  logic rdS, wrS;
  logic [NUM_CHAN-1:0] csS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;
  ctrlStrb_t strb;

  // Address and data share the strobe pipeline so they stay aligned
  hostBusSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .IDLE_VAL(SYNC_IDLE)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({rdN, wrN, csN, addrIn, dataIn}),
    .syncOut(syncBus)
  );
  assign {rdS, wrS, csS, addrS, dataS} = syncBus;

  hostBusCtrl #(.NUM_CHAN(NUM_CHAN)) uCtrl (
    .clk(clk), .rstN(rstN), .modeSep(modeSep),
    .rdS(rdS), .wrS(wrS), .csS(csS),
    .strb(strb), .reqRead(reqRead), .reqWrite(reqWrite), .dataOe(dataOe)
  );

  hostBusDatapath #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .modeSep(modeSep),
    .csS(csS), .addrS(addrS), .dataS(dataS), .strb(strb),
    .regRdData(regRdData),
    .reqChan(reqChan), .reqReg(reqReg), .reqWData(reqWData), .dataOut(dataOut)
  );

  AST_OUT_STABLE_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rstN) (dataOe && $past(dataOe)) |-> $stable(dataOut)); // R10
  AST_OE_AFTER_READ_REQ: assert property (@(posedge clk) disable iff (!rstN) $rose(dataOe) |-> $past(reqRead)); // R3

endmodule

// File: tb/hostBusPort_test.sv
module hostBusPort_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSep = 1'b1;
  logic rdN = 1'b1;
  logic wrN = 1'b1;
  logic [3:0] csN = 4'hF;
  logic [2:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut, reqWData, regRdData;
  logic dataOe, reqRead, reqWrite;
  logic [1:0] reqChan;
  logic [2:0] reqReg;

  int checks = 0;
  int failures = 0;
  int rdCnt = 0, wrCnt = 0, wideErr = 0;
  int lastChan = 0, lastReg = 0, lastWData = 0;
  logic prevRead = 1'b0, prevWrite = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] regModel(input int c, input int r);
    return 8'(((c * 8 + r) * 37) + 11);
  endfunction

  assign regRdData = regModel(int'(reqChan), int'(reqReg));

  hostBusPort uut (
    .clk(clk), .rstN(rstN), .modeSep(modeSep), .rdN(rdN), .wrN(wrN), .csN(csN),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .reqRead(reqRead), .reqWrite(reqWrite), .reqChan(reqChan), .reqReg(reqReg),
    .reqWData(reqWData), .regRdData(regRdData)
  );

  // Request monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (reqRead) begin rdCnt++; lastChan = int'(reqChan); lastReg = int'(reqReg); end
      if (reqWrite) begin wrCnt++; lastChan = int'(reqChan); lastReg = int'(reqReg); lastWData = int'(reqWData); end
      if ((reqRead && prevRead) || (reqWrite && prevWrite) || (reqRead && reqWrite)) wideErr++;
      prevRead = reqRead;
      prevWrite = reqWrite;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearCounts();
    rdCnt = 0; wrCnt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sepRead(input int c, input int r);
    clearCounts();
    @(negedge clk); csN = ~(4'b1 << c); addrIn = 3'(r);
    idle(1); rdN = 1'b0;
    idle(8);
    chk("R3", "oe during read", int'(dataOe), 1);
    chk("R3", "read byte", int'(dataOut), int'(regModel(c, r)));
    chk("R3", "read chan", lastChan, c);
    chk("R3", "read reg", lastReg, r);
    addrIn = ~addrIn;
    idle(3);
    chk("R10", "byte held", int'(dataOut), int'(regModel(c, r)));
    rdN = 1'b1;
    idle(6);
    chk("R10", "oe released", int'(dataOe), 0);
    chk("R9", "one read", rdCnt, 1);
    chk("R9", "no write", wrCnt, 0);
    csN = 4'hF;
    idle(3);
  endtask

  task automatic sepWrite(input int c, input int r, input logic [7:0] fin);
    clearCounts();
    @(negedge clk); csN = ~(4'b1 << c); addrIn = 3'(r); dataIn = ~fin;
    idle(1); wrN = 1'b0;
    idle(5);
    chk("R10", "oe in write", int'(dataOe), 0);
    dataIn = fin;
    idle(2); wrN = 1'b1;
    idle(1); dataIn = 8'h5A ^ fin;
    idle(6);
    chk("R4", "one write", wrCnt, 1);
    chk("R4", "write chan", lastChan, c);
    chk("R4", "write reg", lastReg, r);
    chk("R4", "late data", lastWData, int'(fin));
    chk("R9", "no read", rdCnt, 0);
    csN = 4'hF;
    idle(3);
  endtask

  task automatic combAccess(input int c, input int r, input bit isRead, input logic [7:0] fin);
    clearCounts();
    @(negedge clk); csN = {1'(r & 1), 2'(c), 1'b1}; addrIn = 3'(r); wrN = isRead; dataIn = ~fin;
    idle(1); rdN = 1'b0;
    idle(1); csN[0] = 1'b0;
    idle(2); rdN = 1'b1;
    idle(2); rdN = 1'b0; csN[3] = ~csN[3];
    idle(3);
    if (isRead) begin
      chk("R8", "oe during read", int'(dataOe), 1);
      chk("R7", "read chan", lastChan, c);
      chk("R8", "read byte", int'(dataOut), int'(regModel(c, r)));
    end else begin
      chk("R6", "oe in write", int'(dataOe), 0);
      dataIn = fin;
    end
    idle(2); csN[0] = 1'b1;
    idle(1); dataIn = 8'hC3 ^ fin; rdN = 1'b1;
    idle(6);
    chk("R10", "oe released", int'(dataOe), 0);
    chk("R6", "read count", rdCnt, isRead ? 1 : 0);
    chk("R6", "write count", wrCnt, isRead ? 0 : 1);
    chk("R7", "chan", lastChan, c);
    chk("R7", "reg", lastReg, r);
    if (!isRead) chk("R8", "commit data", lastWData, int'(fin));
    wrN = 1'b1; csN = 4'hF;
    idle(3);
  endtask

  task automatic sepBadSelect(input logic [3:0] pattern, input bit doRead);
    clearCounts();
    @(negedge clk); csN = pattern; addrIn = 3'd5;
    idle(1);
    if (doRead) rdN = 1'b0; else wrN = 1'b0;
    idle(8);
    chk("R5", "oe with bad select", int'(dataOe), 0);
    rdN = 1'b1; wrN = 1'b1;
    idle(6);
    chk("R5", "reads with bad select", rdCnt, 0);
    chk("R5", "writes with bad select", wrCnt, 0);
    csN = 4'hF;
    idle(3);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R2", "reqRead at reset", int'(reqRead), 0);
    chk("R2", "reqWrite at reset", int'(reqWrite), 0);
    chk("R2", "oe at reset", int'(dataOe), 0);
    rstN = 1'b1;
    idle(4);
    chk("R2", "oe after reset", int'(dataOe), 0);
    chk("R2", "no requests after reset", rdCnt + wrCnt, 0);

    // Separate-strobe mode (R1: modeSep = 1)
    modeSep = 1'b1;
    idle(2);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 8; r++) sepRead(c, r);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 8; r++) sepWrite(c, r, 8'((c * 61 + r * 23) ^ 8'h96));
    sepBadSelect(4'b1100, 1'b1);
    sepBadSelect(4'b0000, 1'b0);
    sepBadSelect(4'b1111, 1'b1);
    sepBadSelect(4'b0110, 1'b0);

    // R1: combined pins toggled in separate mode make no request
    clearCounts();
    csN = 4'b1110; wrN = 1'b1; idle(2); csN = 4'hF; idle(6);
    chk("R1", "device select ignored in separate mode", rdCnt + wrCnt, 0);

    // Combined-strobe mode (R1: modeSep = 0)
    modeSep = 1'b0;
    idle(2);
    clearCounts();
    rdN = 1'b0; idle(4); rdN = 1'b1; idle(6);
    chk("R6", "read strobe ignored in combined mode", rdCnt + wrCnt, 0);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 8; r++) combAccess(c, r, 1'b1, 8'h00);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 8; r++) combAccess(c, r, 1'b0, 8'((c * 17 + r * 45) ^ 8'h3C));

    chk("R9", "pulse width violations", wideErr, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule